// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

The block gathers single-cycle event pulses from a set of sources arranged in four groups. Each group owns a status register that records pending events and an enable register that decides which sources may record at all. Any pending bit drives one shared, active-low interrupt request. The request is open-drain in style: it is modelled as an output enable with a data value that is always low, so the line floats whenever nothing is pending.

A host reads and writes the block through a small synchronous register port. Through it the host sets the enables, reads status (a read clears the register it reads), and writes a control register. That register holds a suspend bit, which silences the request without touching any enable, and an acknowledge bit. Any change of the acknowledge bit clears every status register at once. An external active-low clear input also wipes all pending status. After reset every source is disabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all status registers, all enable registers and the control register read 0, and `irq_oe_o` is 0.
- R2: An event on a source whose enable bit is 1 sets the matching status bit at the next clock edge, and `irq_oe_o` is 1 from that edge on.
- R3: An event on a source whose enable bit is 0 leaves its status bit at 0, so setting the enable bit later raises no request.
- R4: With `rd_i` high, addresses 0 to 3 return status group 0 to 3 on `rdata_o` in the same cycle, and that group's status is zero after the clock edge.
- R5: An enabled event arriving in the same cycle as a clearing read of its group is set in that group after the edge.
- R6: `irq_oe_o` is 1 exactly when some status bit is set and suspend is 0; when all status is clear it is 0. `irq_o` is always 0.
- R7: A write to the control register whose bit 1 (acknowledge) differs from its stored value clears all status at that edge, while enabled events in the same cycle are kept; a write that leaves bit 1 unchanged clears nothing.
- R8: Control bit 0 (suspend) at 1 holds `irq_oe_o` at 0 and leaves status and enable contents unchanged.
- R9: While `clr_ni` is 0, every status register is cleared at each edge, overriding events in that cycle.
- R10: Addresses 4 to 7 are the read/write enable registers of groups 0 to 3, address 8 is the control register (bits 1:0), writes to addresses 0 to 3 are ignored, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, group g in bits [8g+7:8g] |
| clr_ni | input | 1 | Clear all pending status, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (clears status when reading it) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_i` |
| irq_oe_o | output | 1 | Request drive enable; 0 means the line floats |
| irq_o | output | 1 | Request data value, always 0 |

## Verification
Read data is combinational and due in the same cycle as the read strobe. Every register effect (status set, read clear, acknowledge clear, external clear, enable and control writes) is due one edge after its stimulus, and the request enable follows in that same cycle. The bench drives inputs at the falling edge and compares all outputs with a behavioural model shortly after that edge. It does this on every cycle, so each result is checked in the cycle it is due and in none before.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned CTRL_SUSPEND_BIT = 0;
  localparam int unsigned CTRL_ACK_BIT     = 1;

  typedef struct packed {
    logic ack;
    logic suspend;
  } ctrl_t;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_clr_i,
  input  logic         clr_all_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q, status_q, set_w;

  assign set_w = evt_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (en_wr_i) begin
      en_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (clr_all_i) begin
      status_q <= '0;
    end else begin
      status_q <= (rd_clr_i ? '0 : status_q) | set_w;
    end
  end

  assign status_o = status_q;
  assign en_o     = en_q;

  // disabled sources never raise a status bit
  p_masked_no_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !clr_all_i && (evt_i & en_q) == '0) |=> (status_q == '0));

  p_event_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !clr_all_i) |=>
      ((status_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_agg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  ctrl_t wdata_i,
  output ctrl_t ctrl_o,
  output logic  ack_pulse_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q <= wdata_i;
    end
  end

  // any change of the acknowledge bit counts as an acknowledge
  assign ack_pulse_o = wr_i && (wdata_i.ack != ctrl_q.ack);
  assign ctrl_o      = ctrl_q;

  p_ack_follows_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pulse_o |=> (ctrl_q.ack != $past(ctrl_q.ack)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned GRP_W   = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] evt_i,
  input  logic                     clr_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [GRP_W-1:0]         wdata_i,
  output logic [GRP_W-1:0]         rdata_o,
  output logic                     irq_oe_o,
  output logic                     irq_o
);
  localparam int unsigned EN_BASE   = NUM_GRP;
  localparam int unsigned CTRL_ADDR = 2 * NUM_GRP;

  logic [NUM_GRP-1:0][GRP_W-1:0] status_w, en_w;
  logic [NUM_GRP-1:0]            pend_w;
  logic                          ctrl_sel, ack_pulse;
  ctrl_t                         ctrl_q, ctrl_wdata;

  assign ctrl_sel   = (addr_i == ADDR_W'(CTRL_ADDR));
  assign ctrl_wdata = ctrl_t'(wdata_i[1:0]);

  irq_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i && ctrl_sel),
    .wdata_i     (ctrl_wdata),
    .ctrl_o      (ctrl_q),
    .ack_pulse_o (ack_pulse)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic stat_sel, en_sel;
    assign stat_sel = (addr_i == ADDR_W'(g));
    assign en_sel   = (addr_i == ADDR_W'(EN_BASE + g));

    irq_group #(.W(GRP_W)) i_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[g*GRP_W +: GRP_W]),
      .en_wr_i   (wr_i && en_sel),
      .wdata_i   (wdata_i),
      .rd_clr_i  ((rd_i && stat_sel) || ack_pulse),
      .clr_all_i (!clr_ni),
      .status_o  (status_w[g]),
      .en_o      (en_w[g])
    );
    assign pend_w[g] = |status_w[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr_i == ADDR_W'(g))           rdata_o = status_w[g];
      if (addr_i == ADDR_W'(EN_BASE + g)) rdata_o = en_w[g];
    end
    if (ctrl_sel) rdata_o[1:0] = ctrl_q;
  end

  assign irq_oe_o = (|pend_w) && !ctrl_q.suspend;
  assign irq_o    = 1'b0;

  p_suspend_gates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.suspend |-> !irq_oe_o);

  p_floats_when_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w == '0) |-> !irq_oe_o);

  p_ext_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (status_w == '0));

  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_pulse && clr_ni && evt_i == '0) |=> (status_w == '0));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NG = 4;
  localparam int GW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NG*GW-1:0] evt = '0;
  logic          clr_n = 1;
  logic [3:0]    addr = '0;
  logic          wr = 0, rd = 0;
  logic [GW-1:0] wdata = '0;
  logic [GW-1:0] rdata;
  logic          irq_oe, irq;

  int checks = 0, errors = 0;
  int m_stat[NG], m_en[NG];
  int m_susp = 0, m_ack = 0;

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .clr_ni(clr_n),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .irq_oe_o(irq_oe), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_rdata(input int a);
    if (a < NG) return m_stat[a];
    if (a < 2*NG) return m_en[a-NG];
    if (a == 2*NG) return (m_ack << 1) | m_susp;
    return 0;
  endfunction

  function automatic bit model_oe();
    int any = 0;
    for (int g = 0; g < NG; g++) any |= m_stat[g];
    return (any != 0) && (m_susp == 0);
  endfunction

  // reference model, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_stat[g] = 0; m_en[g] = 0; end
      m_susp = 0; m_ack = 0;
    end else begin
      bit ackp;
      int old_en[NG];
      ackp = wr && addr == 2*NG && wdata[1] != m_ack[0];
      for (int g = 0; g < NG; g++) old_en[g] = m_en[g];
      for (int g = 0; g < NG; g++) begin
        int s;
        s = int'(evt[g*GW +: GW]) & old_en[g];
        if (!clr_n) m_stat[g] = 0;
        else if ((rd && addr == g) || ackp) m_stat[g] = s;
        else m_stat[g] = m_stat[g] | s;
      end
      if (wr && addr >= NG && addr < 2*NG) m_en[addr-NG] = wdata;
      if (wr && addr == 2*NG) begin m_susp = wdata[0]; m_ack = wdata[1]; end
    end
  end

  // per-cycle comparison after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(irq_oe == model_oe(), "R6 irq_oe", irq_oe, model_oe());
      chk(irq == 1'b0, "R6 irq_o", irq, 0);
      if (rd) chk(rdata == GW'(model_rdata(addr)), "R10 rdata", rdata, model_rdata(addr));
    end
  end

  task automatic idle();
    @(negedge clk); wr = 0; rd = 0; evt = '0; clr_n = 1;
  endtask
  task automatic wreg(input int a, input int d);
    @(negedge clk); wr = 1; rd = 0; addr = 4'(a); wdata = GW'(d); evt = '0;
    @(negedge clk); wr = 0;
  endtask
  task automatic pulse(input int g, input int bits);
    @(negedge clk); wr = 0; rd = 0; evt = '0; evt[g*GW +: GW] = GW'(bits);
    @(negedge clk); evt = '0;
  endtask
  task automatic rreg(input int a, input int exp, input string tag);
    @(negedge clk); wr = 0; rd = 1; addr = 4'(a); evt = '0;
    #1 chk(rdata == GW'(exp), tag, rdata, exp);
    @(negedge clk); rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 chk(irq_oe == 0, "R1 irq_oe", irq_oe, 0);
    for (int a = 0; a <= 2*NG; a++) rreg(a, 0, "R1 reset value");

    // R3: disabled source
    pulse(0, 8'h01);
    wreg(NG + 0, 8'hFF);
    #1 chk(irq_oe == 0, "R3 no spurious irq", irq_oe, 0);
    rreg(0, 0, "R3 status stays clear");

    // R2 / R4 / R6
    pulse(0, 8'h08);
    #1 chk(irq_oe == 1, "R2 irq asserted", irq_oe, 1);
    rreg(0, 8'h08, "R2 status set");
    #1 chk(irq_oe == 0, "R6 floats after clear", irq_oe, 0);
    rreg(0, 0, "R4 read cleared");

    // R5: event during clearing read
    wreg(NG + 1, 8'h0F);
    pulse(1, 8'h01);
    @(negedge clk); rd = 1; addr = 4'd1; evt = '0; evt[GW +: GW] = 8'h02;
    #1 chk(rdata == 8'h01, "R5 read value", rdata, 1);
    idle();
    rreg(1, 8'h02, "R5 event kept");

    // R8: suspend
    pulse(1, 8'h04);
    wreg(2*NG, 1);
    #1 chk(irq_oe == 0, "R8 suspended", irq_oe, 0);
    rreg(NG + 1, 8'h0F, "R8 enable untouched");
    wreg(2*NG, 0);
    #1 chk(irq_oe == 1, "R8 resumes", irq_oe, 1);

    // R7: acknowledge toggle
    wreg(2*NG, 2);
    #1 chk(irq_oe == 0, "R7 ack clears", irq_oe, 0);
    pulse(1, 8'h08);
    wreg(2*NG, 2);
    rreg(1, 8'h08, "R7 same ack no clear");

    // R9: external clear overrides events
    pulse(0, 8'h10);
    @(negedge clk); clr_n = 0; evt = '0; evt[0 +: GW] = 8'h20;
    idle();
    #1 chk(irq_oe == 0, "R9 clear all", irq_oe, 0);
    rreg(0, 0, "R9 status zero");

    // R10: map
    @(negedge clk); wr = 1; addr = 4'd2; wdata = 8'hAA;
    idle();
    rreg(2, 0, "R10 status write ignored");
    rreg(15, 0, "R10 unused address");
    rreg(2*NG, 2, "R10 control readback");

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      evt   = $urandom & $urandom;
      addr  = 4'($urandom_range(0, 9));
      rd    = ($urandom_range(0, 3) == 0);
      wr    = !rd && ($urandom_range(0, 7) == 0);
      wdata = GW'($urandom);
      clr_n = ($urandom_range(0, 63) != 0);
    end
    idle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule